// File: doc/BRIEF.md
# Multi-Channel Word FIFO Bank with Sticky Error Flags

This block holds a pair of word-wide FIFOs for each of several processing channels. In the outbound (transmit) direction a bus host writes words and the channel drains them with a pop strobe. In the inbound (receive) direction the channel fills the FIFO with a push strobe and the host reads the words back. For each FIFO, in both directions, the block reports the current fill level and full and empty status. It also drives a level-based request line that a transfer engine can use for pacing.

Host accesses that cannot complete are dropped without disturbing the FIFO. A write to a full transmit FIFO and a read of an empty receive FIFO each set a per-channel sticky debug flag. The host clears a flag by writing a one to its bit. A per-channel flush input empties both FIFOs of that channel in one cycle. The flush leaves the other channels and the debug flags as they are.

The host selects a channel with an index on each of its write and read ports. A write and a read may be issued in the same cycle. Read data is combinational from the head of the selected receive FIFO.

Top module: `chan_fifo_bank`

## Requirements
- R1: A host write to a transmit FIFO that is not full appends the word. `chan_tx_data` for that channel shows the oldest word, and each channel pop removes it, so words leave in the order they were written.
- R2: A host write to a full transmit FIFO leaves its level unchanged. The words popped afterwards are exactly those stored before the write.
- R3: A host write to a full transmit FIFO sets `err_tx_over` for that channel from the next cycle. This holds even if the same channel is flushed in that cycle.
- R4: A channel push into a receive FIFO that is not full stores the word. `host_rd_data` shows the oldest word of the channel selected by `host_rd_ch` in the same cycle, and a host read removes that word.
- R5: A host read of an empty receive FIFO is ignored: the FIFO stays empty and its level stays 0. The returned data is undefined.
- R6: A host read of an empty receive FIFO sets `err_rx_under` for that channel from the next cycle.
- R7: A sticky flag stays set until a cycle in which its clear bit is 1 and no new error for it occurs. A clear and a new error in the same cycle leave the flag set. A clear bit affects only its own flag.
- R8: Each FIFO's level output (a count of 0 to DEPTH, `LVL_W` bits per channel, channel c at bits c*LVL_W upward) updates one cycle after the accepted operation. Full is 1 exactly when the level equals DEPTH, and empty is 1 exactly when the level is 0.
- R9: Asserting `flush[c]` empties both FIFOs of channel c by the next cycle, even if a push, pop, write or read to that channel occurs in the same cycle. Other channels and all sticky flags are unaffected.
- R10: `tx_req[c]` is 1 while the transmit FIFO of channel c is not full. `rx_req[c]` is 1 while its receive FIFO is not empty.
- R11: A channel pop of an empty transmit FIFO, or a channel push into a full receive FIFO, is ignored and sets no flag.
- R12: After reset every FIFO is empty with level 0 and every sticky flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr_en | input | 1 | Host write strobe into a transmit FIFO |
| host_wr_ch | input | CH_W | Channel index for the host write |
| host_wr_data | input | WIDTH | Host write word |
| host_rd_en | input | 1 | Host read strobe from a receive FIFO |
| host_rd_ch | input | CH_W | Channel index for the host read |
| host_rd_data | output | WIDTH | Head word of the selected receive FIFO |
| chan_pop | input | NUM_CH | Per-channel transmit pop strobe |
| chan_tx_data | output | NUM_CH*WIDTH | Per-channel transmit head word |
| chan_push | input | NUM_CH | Per-channel receive push strobe |
| chan_rx_data | input | NUM_CH*WIDTH | Per-channel receive push word |
| flush | input | NUM_CH | Per-channel flush of both FIFOs |
| tx_level | output | NUM_CH*LVL_W | Transmit fill levels |
| rx_level | output | NUM_CH*LVL_W | Receive fill levels |
| tx_full | output | NUM_CH | Transmit FIFO full |
| tx_empty | output | NUM_CH | Transmit FIFO empty |
| rx_full | output | NUM_CH | Receive FIFO full |
| rx_empty | output | NUM_CH | Receive FIFO empty |
| tx_req | output | NUM_CH | Transmit space request |
| rx_req | output | NUM_CH | Receive data request |
| err_tx_over | output | NUM_CH | Sticky host-write overflow flags |
| err_rx_under | output | NUM_CH | Sticky host-read underflow flags |
| clr_tx_over | input | NUM_CH | Write-one-to-clear mask for err_tx_over |
| clr_rx_under | input | NUM_CH | Write-one-to-clear mask for err_rx_under |

## Verification
The bench builds the block with its defaults: four channels, a depth of four and 32-bit words. With a power-of-two depth, the wrapping-pointer variant is elaborated. Filling and draining a FIFO completely walks both pointers through their wrap back to slot 0. The depth is small enough that full and empty are each reached within a few operations. With four channels, an error, flush or clear aimed at one channel can be checked against untouched neighbours on every side.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;

   // True when v is a non-zero power of two.
   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

   // Width of an index able to address n items, never below one bit.
   function automatic int unsigned idx_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/chan_fifo_core.sv
module chan_fifo_core
   import chan_fifo_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,
   output logic [WIDTH-1:0] head_data,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty,
   output logic             push_rej,
   output logic             pop_rej
);
   localparam int unsigned PTR_W = idx_width(DEPTH);

   if (DEPTH < 2) begin : g_chk_depth
      $error("chan_fifo_core: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("chan_fifo_core: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [LVL_W-1:0] count;
   logic             push_ok, pop_ok;

   // Pointer advance: free wrap for power-of-two depths, compare otherwise.
   if (is_pow2(DEPTH)) begin : g_wrap_free
      assign wr_nxt = wr_ptr + PTR_W'(1);
      assign rd_nxt = rd_ptr + PTR_W'(1);
   end else begin : g_wrap_cmp
      assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
      assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
   end

   assign full     = (count == LVL_W'(DEPTH));
   assign empty    = (count == '0);
   assign push_ok  = push && !full && !flush;
   assign pop_ok   = pop && !empty && !flush;
   assign push_rej = push && full;
   assign pop_rej  = pop && empty;

   always_ff @(posedge clk) begin
      if (push_ok) begin
         mem[wr_ptr] <= push_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         unique case ({push_ok, pop_ok})
            2'b10:   count <= count + LVL_W'(1);
            2'b01:   count <= count - LVL_W'(1);
            default: count <= count;
         endcase
      end
   end

   assign head_data = mem[rd_ptr];
   assign level     = count;

   // R2
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop && !flush) |=> $stable(level));
   // R9
   flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (empty && level == '0));
   // R5
   empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
   // R8
   push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !full && !pop && !flush) |=> (level == $past(level) + LVL_W'(1)));

endmodule

// File: rtl/chan_sticky_w1c.sv
module chan_sticky_w1c #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] clr,
   output logic [N-1:0] flag
);
   if (N < 1) begin : g_chk_n
      $error("chan_sticky_w1c: N must be at least 1");
   end

   // A new event outranks a same-cycle clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= '0;
      else        flag <= set | (flag & ~clr);
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      // R3
      set_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> flag[i]);
      // R7
      flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (flag[i] && !clr[i]) |=> flag[i]);
      // R7
      flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !set[i]) |=> !flag[i]);
   end

endmodule

// File: rtl/chan_fifo_lane.sv
module chan_fifo_lane #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             host_wr,
   input  logic [WIDTH-1:0] host_wr_data,
   input  logic             chan_pop,
   output logic [WIDTH-1:0] tx_head,
   input  logic             chan_push,
   input  logic [WIDTH-1:0] chan_rx_data,
   input  logic             host_rd,
   output logic [WIDTH-1:0] rx_head,
   output logic [LVL_W-1:0] tx_level,
   output logic [LVL_W-1:0] rx_level,
   output logic             tx_full,
   output logic             tx_empty,
   output logic             rx_full,
   output logic             rx_empty,
   output logic             tx_req,
   output logic             rx_req,
   output logic             tx_over_evt,
   output logic             rx_under_evt
);
   logic tx_pop_rej, rx_push_rej;

   chan_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (host_wr),
      .push_data (host_wr_data),
      .pop       (chan_pop),
      .head_data (tx_head),
      .level     (tx_level),
      .full      (tx_full),
      .empty     (tx_empty),
      .push_rej  (tx_over_evt),
      .pop_rej   (tx_pop_rej)
   );

   chan_fifo_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .push      (chan_push),
      .push_data (chan_rx_data),
      .pop       (host_rd),
      .head_data (rx_head),
      .level     (rx_level),
      .full      (rx_full),
      .empty     (rx_empty),
      .push_rej  (rx_push_rej),
      .pop_rej   (rx_under_evt)
   );

   assign tx_req = !tx_full;
   assign rx_req = !rx_empty;

   // R4
   host_read_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !rx_empty && !chan_push && !flush)
         |=> (rx_level == $past(rx_level) - LVL_W'(1)));
   // R11
   chan_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_pop_rej && !host_wr) |=> tx_empty);
   // R11
   chan_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_push_rej && !host_rd && !flush) |=> rx_full);

endmodule

// File: rtl/chan_fifo_bank.sv
module chan_fifo_bank
   import chan_fifo_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned DEPTH  = 4,
   localparam int unsigned CH_W  = idx_width(NUM_CH),
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    host_wr_en,
   input  logic [CH_W-1:0]         host_wr_ch,
   input  logic [WIDTH-1:0]        host_wr_data,
   input  logic                    host_rd_en,
   input  logic [CH_W-1:0]         host_rd_ch,
   output logic [WIDTH-1:0]        host_rd_data,
   input  logic [NUM_CH-1:0]       chan_pop,
   output logic [NUM_CH*WIDTH-1:0] chan_tx_data,
   input  logic [NUM_CH-1:0]       chan_push,
   input  logic [NUM_CH*WIDTH-1:0] chan_rx_data,
   input  logic [NUM_CH-1:0]       flush,
   output logic [NUM_CH*LVL_W-1:0] tx_level,
   output logic [NUM_CH*LVL_W-1:0] rx_level,
   output logic [NUM_CH-1:0]       tx_full,
   output logic [NUM_CH-1:0]       tx_empty,
   output logic [NUM_CH-1:0]       rx_full,
   output logic [NUM_CH-1:0]       rx_empty,
   output logic [NUM_CH-1:0]       tx_req,
   output logic [NUM_CH-1:0]       rx_req,
   output logic [NUM_CH-1:0]       err_tx_over,
   output logic [NUM_CH-1:0]       err_rx_under,
   input  logic [NUM_CH-1:0]       clr_tx_over,
   input  logic [NUM_CH-1:0]       clr_rx_under
);
   if (NUM_CH < 1) begin : g_chk_ch
      $error("chan_fifo_bank: NUM_CH must be at least 1");
   end

   logic [NUM_CH-1:0] wr_sel, rd_sel;
   logic [NUM_CH-1:0] over_evt, under_evt;
   logic [WIDTH-1:0]  rx_head [NUM_CH];

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      assign wr_sel[c] = host_wr_en && (host_wr_ch == CH_W'(c));
      assign rd_sel[c] = host_rd_en && (host_rd_ch == CH_W'(c));

      chan_fifo_lane #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_lane (
         .clk          (clk),
         .rst_n        (rst_n),
         .flush        (flush[c]),
         .host_wr      (wr_sel[c]),
         .host_wr_data (host_wr_data),
         .chan_pop     (chan_pop[c]),
         .tx_head      (chan_tx_data[c*WIDTH +: WIDTH]),
         .chan_push    (chan_push[c]),
         .chan_rx_data (chan_rx_data[c*WIDTH +: WIDTH]),
         .host_rd      (rd_sel[c]),
         .rx_head      (rx_head[c]),
         .tx_level     (tx_level[c*LVL_W +: LVL_W]),
         .rx_level     (rx_level[c*LVL_W +: LVL_W]),
         .tx_full      (tx_full[c]),
         .tx_empty     (tx_empty[c]),
         .rx_full      (rx_full[c]),
         .rx_empty     (rx_empty[c]),
         .tx_req       (tx_req[c]),
         .rx_req       (rx_req[c]),
         .tx_over_evt  (over_evt[c]),
         .rx_under_evt (under_evt[c])
      );
   end

   always_comb begin
      host_rd_data = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (host_rd_ch == CH_W'(c)) host_rd_data = rx_head[c];
      end
   end

   chan_sticky_w1c #(.N(NUM_CH)) u_over_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (over_evt),
      .clr   (clr_tx_over),
      .flag  (err_tx_over)
   );

   chan_sticky_w1c #(.N(NUM_CH)) u_under_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (under_evt),
      .clr   (clr_rx_under),
      .flag  (err_rx_under)
   );

   // R1
   one_write_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_sel));
   // R9
   flush_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|flush && over_evt == '0 && clr_tx_over == '0) |=> $stable(err_tx_over));

endmodule

// File: tb/chan_fifo_bank_bench.sv
`timescale 1ns/1ps
module chan_fifo_bank_bench;
   localparam int NC = 4;
   localparam int W  = 32;
   localparam int D  = 4;
   localparam int LW = 3;
   localparam int CW = 2;

   localparam logic [1:0] OP_HWR = 2'd0, OP_CPOP = 2'd1, OP_CPUSH = 2'd2, OP_HRD = 2'd3;

   function automatic logic [39:0] mk(input logic [1:0] op, input logic [1:0] ch,
                                      input logic dc, input logic [31:0] d, input logic [2:0] lv);
      return {op, ch, dc, d, lv};
   endfunction

   // Each vector: operation, channel, check-data flag, data, expected level afterwards.
   localparam int NV = 16;
   localparam logic [39:0] VEC [NV] = '{
      mk(OP_HWR,  2'd0, 1'b0, 32'hA000_0000, 3'd1),
      mk(OP_HWR,  2'd0, 1'b0, 32'hA000_0001, 3'd2),
      mk(OP_HWR,  2'd0, 1'b0, 32'hA000_0002, 3'd3),
      mk(OP_HWR,  2'd0, 1'b0, 32'hA000_0003, 3'd4),
      mk(OP_HWR,  2'd0, 1'b0, 32'hDEAD_BEEF, 3'd4),
      mk(OP_CPOP, 2'd0, 1'b1, 32'hA000_0000, 3'd3),
      mk(OP_CPOP, 2'd0, 1'b1, 32'hA000_0001, 3'd2),
      mk(OP_CPOP, 2'd0, 1'b1, 32'hA000_0002, 3'd1),
      mk(OP_CPOP, 2'd0, 1'b1, 32'hA000_0003, 3'd0),
      mk(OP_CPOP, 2'd0, 1'b0, 32'h0,         3'd0),
      mk(OP_CPUSH,2'd1, 1'b0, 32'hB000_0000, 3'd1),
      mk(OP_CPUSH,2'd1, 1'b0, 32'hB000_0001, 3'd2),
      mk(OP_HRD,  2'd1, 1'b1, 32'hB000_0000, 3'd1),
      mk(OP_HRD,  2'd1, 1'b1, 32'hB000_0001, 3'd0),
      mk(OP_HRD,  2'd1, 1'b0, 32'h0,         3'd0),
      mk(OP_HWR,  2'd1, 1'b0, 32'hC000_0000, 3'd1)
   };

   logic            clk = 1'b0;
   logic            rst_n;
   logic            host_wr_en, host_rd_en;
   logic [CW-1:0]   host_wr_ch, host_rd_ch;
   logic [W-1:0]    host_wr_data, host_rd_data;
   logic [NC-1:0]   chan_pop, chan_push, flush, clr_tx_over, clr_rx_under;
   logic [NC*W-1:0] chan_tx_data, chan_rx_data;
   logic [NC*LW-1:0] tx_level, rx_level;
   logic [NC-1:0]   tx_full, tx_empty, rx_full, rx_empty, tx_req, rx_req;
   logic [NC-1:0]   err_tx_over, err_rx_under;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   chan_fifo_bank #(.NUM_CH(NC), .WIDTH(W), .DEPTH(D)) u_chan_fifo_bank (
      .clk(clk), .rst_n(rst_n),
      .host_wr_en(host_wr_en), .host_wr_ch(host_wr_ch), .host_wr_data(host_wr_data),
      .host_rd_en(host_rd_en), .host_rd_ch(host_rd_ch), .host_rd_data(host_rd_data),
      .chan_pop(chan_pop), .chan_tx_data(chan_tx_data),
      .chan_push(chan_push), .chan_rx_data(chan_rx_data),
      .flush(flush),
      .tx_level(tx_level), .rx_level(rx_level),
      .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
      .tx_req(tx_req), .rx_req(rx_req),
      .err_tx_over(err_tx_over), .err_rx_under(err_rx_under),
      .clr_tx_over(clr_tx_over), .clr_rx_under(clr_rx_under)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic idle();
      host_wr_en = 1'b0; host_rd_en = 1'b0;
      host_wr_ch = '0;   host_rd_ch = '0;   host_wr_data = '0;
      chan_pop = '0; chan_push = '0; chan_rx_data = '0; flush = '0;
      clr_tx_over = '0; clr_rx_under = '0;
   endtask

   // Advance to just after the next rising edge.
   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic hwr(input int ch, input logic [31:0] d);
      host_wr_en = 1'b1; host_wr_ch = CW'(ch); host_wr_data = d;
      #1; tick(); idle();
   endtask

   task automatic cpush(input int ch, input logic [31:0] d);
      chan_push[ch] = 1'b1; chan_rx_data[ch*W +: W] = d;
      #1; tick(); idle();
   endtask

   function automatic logic [2:0] txl(input int ch);
      return tx_level[ch*LW +: LW];
   endfunction
   function automatic logic [2:0] rxl(input int ch);
      return rx_level[ch*LW +: LW];
   endfunction

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // Reset state
      for (int c = 0; c < NC; c++) begin
         chk("R12 tx level", 32'(txl(c)), 32'd0);
         chk("R12 rx level", 32'(rxl(c)), 32'd0);
      end
      chk("R12 tx_empty", 32'(tx_empty), 32'hF);
      chk("R12 rx_empty", 32'(rx_empty), 32'hF);
      chk("R12 flags", 32'({err_tx_over, err_rx_under}), 32'h0);
      chk("R10 reset tx_req", 32'(tx_req), 32'hF);
      chk("R10 reset rx_req", 32'(rx_req), 32'h0);

      // Vector walk: R1 R2 R4 R5 R8 R11
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         logic [1:0]  op;
         int          ch;
         v  = VEC[i];
         op = v[39:38];
         ch = int'(v[37:36]);
         unique case (op)
            OP_HWR:   begin host_wr_en = 1'b1; host_wr_ch = CW'(ch); host_wr_data = v[34:3]; end
            OP_CPOP:  chan_pop[ch] = 1'b1;
            OP_CPUSH: begin chan_push[ch] = 1'b1; chan_rx_data[ch*W +: W] = v[34:3]; end
            default:  begin host_rd_en = 1'b1; host_rd_ch = CW'(ch); end
         endcase
         #1;
         if (v[35]) begin
            if (op == OP_CPOP) chk("R1 tx order", chan_tx_data[ch*W +: W], v[34:3]);
            else               chk("R4 rx head",  host_rd_data, v[34:3]);
         end
         tick();
         idle();
         if (op == OP_HWR || op == OP_CPOP) chk("R8/R2/R11 tx level", 32'(txl(ch)), 32'(v[2:0]));
         else                               chk("R8/R5 rx level",     32'(rxl(ch)), 32'(v[2:0]));
      end
      chk("R3 overflow flag", 32'(err_tx_over), 32'b0001);
      chk("R6 underflow flag", 32'(err_rx_under), 32'b0010);
      chk("R5 rx stays empty", 32'(rx_empty[1]), 32'd1);

      // R7: clear of a different bit does nothing; clear with new error keeps flag
      clr_rx_under = 4'b0001; #1; tick(); idle();
      chk("R7 other bit", 32'({err_tx_over, err_rx_under}), 32'h12);
      host_rd_en = 1'b1; host_rd_ch = 2'd1; clr_rx_under = 4'b0010; #1; tick(); idle();
      chk("R7 set beats clear", 32'(err_rx_under), 32'b0010);
      clr_rx_under = 4'b0010; #1; tick(); idle();
      chk("R7 cleared rx", 32'(err_rx_under), 32'b0000);
      clr_tx_over = 4'b0001; #1; tick(); idle();
      chk("R7 cleared tx", 32'(err_tx_over), 32'b0000);

      // R9: flush channel 2 while writing to it; channel 3 untouched
      cpush(2, 32'h2200_0000); cpush(2, 32'h2200_0001);
      hwr(2, 32'h2000_0000); hwr(2, 32'h2000_0001);
      hwr(3, 32'h3000_0000);
      flush[2] = 1'b1; host_wr_en = 1'b1; host_wr_ch = 2'd2; host_wr_data = 32'h2BAD;
      chan_push[2] = 1'b1; chan_rx_data[2*W +: W] = 32'h2BAD;
      #1; tick(); idle();
      chk("R9 tx flushed", 32'(txl(2)), 32'd0);
      chk("R9 rx flushed", 32'(rxl(2)), 32'd0);
      chk("R9 neighbour", 32'(txl(3)), 32'd1);
      chk("R9 flags kept", 32'({err_tx_over, err_rx_under}), 32'h0);
      hwr(2, 32'h2000_00C9);
      chk("R9 fresh head", chan_tx_data[2*W +: W], 32'h2000_00C9);

      // R10/R8: fill channel 3 transmit FIFO
      hwr(3, 32'h3000_0001); hwr(3, 32'h3000_0002);
      chk("R8 not yet full", 32'(tx_full[3]), 32'd0);
      hwr(3, 32'h3000_0003);
      chk("R8 tx_full", 32'(tx_full[3]), 32'd1);
      chk("R10 tx_req low when full", 32'(tx_req[3]), 32'd0);
      chk("R8 tx_empty low", 32'(tx_empty[3]), 32'd0);

      // R11: overfill channel 3 receive FIFO from the channel side
      for (int k = 0; k < 5; k++) cpush(3, 32'h3300_0000 + 32'(k));
      chk("R11 rx level capped", 32'(rxl(3)), 32'd4);
      chk("R8 rx_full", 32'(rx_full[3]), 32'd1);
      chk("R10 rx_req", 32'(rx_req[3]), 32'd1);
      chk("R11 no flag", 32'({err_tx_over, err_rx_under}), 32'h0);
      host_rd_ch = 2'd3; #1;
      chk("R11 oldest kept", host_rd_data, 32'h3300_0000);
      idle();

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule